// File: doc/BRIEF.md
# Predicated Element Step Skipper

This block sits beside the issue controller of a vector-capable core. On every evaluation request it looks at the current element step on the source side and on the destination side. For each side it checks the predicate mask bit at that step. If the bit is clear, the side is not in zeroing mode, and the step is still below the vector length, the block moves the step forward. The new step is the next enabled element. If no enabled element is left below the vector length, the new step is the vector length itself.

The two sides are computed independently, and the results are registered. One cycle after the request, a result-valid pulse presents the new steps. If either step moved, an update pulse is raised in the same cycle, so that the controller re-decodes the instruction with the new step state. Fetching masks, decoding instructions and executing them are handled elsewhere.

Top module: `pred_step_skip`

## Requirements
- R1: After synchronous reset, both step outputs are 0, and `res_valid_o` and `update_o` are low.
- R2: When the mask bit at the current step is set, that side's step output equals its input step. In particular, an all-ones mask leaves both steps unchanged.
- R3: When the mask bit at the current step is clear, the step is below the vector length, and zeroing is off, the new step is the lowest mask bit position that is at or above the current step and below the vector length. Mask bit i stands for element i.
- R4: When no mask bit is set in the range from the current step up to (but not including) the vector length, the new step equals the vector length.
- R5: With the side's zeroing flag set, that side's step is never changed.
- R6: A step at or above the vector length is returned unchanged, so no step ever moves past the vector length.
- R7: A vector length of 0 changes neither step and raises no update pulse.
- R8: The source result depends only on the source mask, step and zeroing flag (plus the vector length). The same holds for the destination side.
- R9: `res_valid_o` is a one-cycle pulse exactly one cycle after each cycle with `eval_i` high. `update_o` is high in that cycle only if at least one step output differs from its input step.
- R10: Between evaluations, the step outputs hold their last values and both pulses stay low.
- R11: A vector length above 64 is treated as 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eval_i | input | 1 | Evaluation request, one cycle per element |
| src_mask_i | input | 64 | Source predicate mask, bit i for element i |
| dst_mask_i | input | 64 | Destination predicate mask |
| src_step_i | input | 7 | Current source element step |
| dst_step_i | input | 7 | Current destination element step |
| vl_i | input | 7 | Vector length |
| src_zero_i | input | 1 | Source zeroing mode, disables skipping |
| dst_zero_i | input | 1 | Destination zeroing mode, disables skipping |
| src_step_o | output | 7 | Registered new source step |
| dst_step_o | output | 7 | Registered new destination step |
| res_valid_o | output | 1 | One-cycle pulse: results valid |
| update_o | output | 1 | One-cycle pulse: a step changed, re-decode |

## Verification
The hardest situation to reach is a masked-out step whose search runs off the end of the enabled range. This happens when mask bits are set only at or above the vector length, or only below the current step. The step must then land exactly on the vector length, not on a later set bit. The stimulus builds such masks on purpose: a single bit above VL, bits below the step, and a zero mask with VL above 64. Random masks with sparse and dense bit densities are then mixed with independent step, VL and zeroing values on each side. Every cycle is compared with a behavioural model.

// File: rtl/pss_pkg.sv
package pss_pkg;
    localparam int EL_MAX = 64;
    localparam int STEP_W = $clog2(EL_MAX + 1);

    typedef logic [EL_MAX-1:0] mask_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef struct packed {
        step_t step;
        logic  moved;
    } side_res_t;

    function automatic step_t clamp_vl(input step_t vl);
        return (vl > step_t'(EL_MAX)) ? step_t'(EL_MAX) : vl;
    endfunction

    function automatic logic mask_bit(input mask_t m, input step_t idx);
        logic b;
        b = 1'b0;
        for (int i = 0; i < EL_MAX; i++)
            if (idx == step_t'(i)) b = m[i];
        return b;
    endfunction
endpackage

// File: rtl/pss_first_one.sv
module pss_first_one
    import pss_pkg::*;
#(
    parameter int N = EL_MAX + 1
) (
    input  logic [N-1:0] vec_i,
    output step_t        idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--)
            if (vec_i[i]) idx_o = step_t'(i);
    end
endmodule

// File: rtl/pss_side.sv
module pss_side
    import pss_pkg::*;
(
    input  mask_t     mask_i,
    input  step_t     step_i,
    input  step_t     vl_i,
    input  logic      zero_i,
    output side_res_t res_o
);
    localparam int N = EL_MAX + 1;

    logic [N-1:0] cand;
    logic [EL_MAX-1:0] at_cur;
    logic cur_en, need_skip;
    step_t first_idx;

    genvar g;
    generate
        for (g = 0; g < EL_MAX; g++) begin : g_cand
            assign cand[g]   = (mask_i[g] && (step_t'(g) >= step_i) && (step_t'(g) < vl_i))
                               || (vl_i == step_t'(g));
            assign at_cur[g] = mask_i[g] && (step_i == step_t'(g));
        end
    endgenerate
    assign cand[EL_MAX] = (vl_i == step_t'(EL_MAX));

    assign cur_en    = |at_cur;
    assign need_skip = !zero_i && (vl_i != '0) && (step_i < vl_i) && !cur_en;

    pss_first_one #(.N(N)) u_first (
        .vec_i (cand),
        .idx_o (first_idx)
    );

    always_comb begin
        res_o.step  = need_skip ? first_idx : step_i;
        res_o.moved = need_skip && (first_idx != step_i);
    end

    always_comb begin
        if (res_o.moved)
            assert_lands_enabled_R3: assert (res_o.step == vl_i || mask_bit(mask_i, res_o.step));
        if (res_o.moved)
            assert_within_vl_R6: assert (res_o.step <= vl_i && res_o.step > step_i);
    end
endmodule

// File: rtl/pred_step_skip.sv
module pred_step_skip
    import pss_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              eval_i,
    input  logic [EL_MAX-1:0] src_mask_i,
    input  logic [EL_MAX-1:0] dst_mask_i,
    input  logic [STEP_W-1:0] src_step_i,
    input  logic [STEP_W-1:0] dst_step_i,
    input  logic [STEP_W-1:0] vl_i,
    input  logic              src_zero_i,
    input  logic              dst_zero_i,
    output logic [STEP_W-1:0] src_step_o,
    output logic [STEP_W-1:0] dst_step_o,
    output logic              res_valid_o,
    output logic              update_o
);
    step_t vl_eff;
    side_res_t src_res, dst_res;

    assign vl_eff = clamp_vl(vl_i);

    pss_side u_src (
        .mask_i (src_mask_i),
        .step_i (src_step_i),
        .vl_i   (vl_eff),
        .zero_i (src_zero_i),
        .res_o  (src_res)
    );

    pss_side u_dst (
        .mask_i (dst_mask_i),
        .step_i (dst_step_i),
        .vl_i   (vl_eff),
        .zero_i (dst_zero_i),
        .res_o  (dst_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_step_o  <= '0;
            dst_step_o  <= '0;
            res_valid_o <= 1'b0;
            update_o    <= 1'b0;
        end else begin
            res_valid_o <= eval_i;
            update_o    <= eval_i && (src_res.moved || dst_res.moved);
            if (eval_i) begin
                src_step_o <= src_res.step;
                dst_step_o <= dst_res.step;
            end
        end
    end

    assert_pulse_owner_R9: assert property (@(posedge clk) disable iff (rst)
        update_o |-> res_valid_o);
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        eval_i |=> res_valid_o);
    assert_zero_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (eval_i && src_zero_i) |=> (src_step_o == $past(src_step_i)));
    assert_vl0_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (eval_i && vl_i == '0) |=> !update_o);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!eval_i && !$past(rst)) |=> ($stable(src_step_o) && $stable(dst_step_o) && !res_valid_o));
    assert_update_means_move_R9: assert property (@(posedge clk) disable iff (rst)
        (eval_i && !src_zero_i) |=> (update_o || src_step_o == $past(src_step_i)));
endmodule

// File: tb/pred_step_skip_bench.sv
module pred_step_skip_bench;
    logic clk = 1'b0;
    logic rst;
    logic eval_i;
    logic [63:0] src_mask_i, dst_mask_i;
    logic [6:0] src_step_i, dst_step_i, vl_i;
    logic src_zero_i, dst_zero_i;
    logic [6:0] src_step_o, dst_step_o;
    logic res_valid_o, update_o;

    int n_chk = 0, n_bad = 0;
    int exp_src = 0, exp_dst = 0;
    bit exp_val = 0, exp_upd = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pred_step_skip u_pred_step_skip (
        .clk(clk), .rst(rst), .eval_i(eval_i),
        .src_mask_i(src_mask_i), .dst_mask_i(dst_mask_i),
        .src_step_i(src_step_i), .dst_step_i(dst_step_i), .vl_i(vl_i),
        .src_zero_i(src_zero_i), .dst_zero_i(dst_zero_i),
        .src_step_o(src_step_o), .dst_step_o(dst_step_o),
        .res_valid_o(res_valid_o), .update_o(update_o)
    );

    function automatic int ref_step(input logic [63:0] m, input int step, input int vl, input bit z);
        int v;
        v = (vl > 64) ? 64 : vl;
        if (z || v == 0 || step >= v) return step;
        for (int i = step; i < v; i++)
            if (m[i]) return i;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(input string req, input bit ev, input logic [63:0] sm, input logic [63:0] dm,
                       input int ss, input int ds, input int vl, input bit sz, input bit dz);
        int ns, nd;
        @(negedge clk);
        eval_i = ev; src_mask_i = sm; dst_mask_i = dm;
        src_step_i = 7'(ss); dst_step_i = 7'(ds); vl_i = 7'(vl);
        src_zero_i = sz; dst_zero_i = dz;
        exp_val = ev;
        exp_upd = 0;
        if (ev) begin
            ns = ref_step(sm, ss, vl, sz);
            nd = ref_step(dm, ds, vl, dz);
            exp_upd = (ns != ss) || (nd != ds);
            exp_src = ns;
            exp_dst = nd;
        end
        @(posedge clk);
        #1;
        check(req, int'(src_step_o), exp_src, "src_step");
        check(req, int'(dst_step_o), exp_dst, "dst_step");
        check(req, int'(res_valid_o), int'(exp_val), "res_valid");
        check(req, int'(update_o), int'(exp_upd), "update");
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; eval_i = 0; src_mask_i = 0; dst_mask_i = 0;
        src_step_i = 0; dst_step_i = 0; vl_i = 0; src_zero_i = 0; dst_zero_i = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", int'(src_step_o), 0, "src_step");
        check("R1", int'(dst_step_o), 0, "dst_step");
        check("R1", int'(res_valid_o), 0, "res_valid");
        check("R1", int'(update_o), 0, "update");
        @(negedge clk); rst = 1'b0;

        cyc("R2", 1, '1, '1, 3, 7, 20, 0, 0);
        cyc("R2", 1, 64'h10, 64'h1, 4, 0, 10, 0, 0);
        cyc("R3", 1, 64'b1010000, 64'h100, 1, 2, 10, 0, 0);
        cyc("R3", 1, 64'h8000_0000_0000_0000, 64'h0, 0, 0, 64, 0, 0);
        cyc("R4", 1, 64'h10_0000, 64'h3, 2, 5, 10, 0, 0);
        cyc("R4", 1, 64'h0, 64'h0, 0, 63, 64, 0, 0);
        cyc("R5", 1, 64'h0, 64'h0, 1, 2, 30, 1, 1);
        cyc("R5", 1, 64'h0, 64'h0, 1, 2, 30, 1, 0);
        cyc("R6", 1, 64'h0, 64'h0, 12, 15, 12, 0, 0);
        cyc("R7", 1, 64'h0, 64'h0, 0, 3, 0, 0, 0);
        cyc("R8", 1, 64'h0, '1, 0, 0, 40, 0, 0);
        cyc("R8", 1, '1, 64'h400, 0, 0, 40, 0, 0);
        cyc("R9", 1, 64'h2, 64'h2, 0, 0, 8, 0, 0);
        cyc("R9", 0, 64'h0, 64'h0, 0, 0, 8, 0, 0);
        cyc("R10", 0, 64'h0, 64'h0, 1, 1, 50, 0, 0);
        cyc("R10", 0, '1, '1, 9, 9, 0, 1, 1);
        cyc("R11", 1, 64'h0, 64'h0, 5, 70, 100, 0, 0);
        cyc("R11", 1, 64'h0, 64'h0, 64, 1, 127, 0, 0);
        cyc("R9", 1, 64'h4, 64'h4, 0, 2, 8, 0, 0);
        cyc("R9", 1, 64'h4, 64'h4, 0, 2, 8, 0, 0);

        for (int k = 0; k < 600; k++) begin
            logic [63:0] sm, dm;
            int vl;
            sm = {$urandom, $urandom};
            dm = {$urandom, $urandom};
            if (k % 3 == 0) begin sm = sm & {$urandom, $urandom} & {$urandom, $urandom}; dm = dm & {$urandom, $urandom}; end
            if (k % 7 == 0) sm = 64'h1 << ($urandom % 64);
            vl = $urandom % 80;
            cyc("R3", ($urandom % 5) != 0, sm, dm, $urandom % 66, $urandom % 66, vl,
                ($urandom % 6) == 0, ($urandom % 6) == 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule